// File: doc/BRIEF.md
# Per-Key Edge Interrupt Unit

This unit sits behind a keypad scanner and watches the debounced status of a 64-key matrix. Each key owns a two-bit edge selector that decides which status transitions are reported: none, rising only, falling only, or both. A qualifying transition sets a sticky flag for that key. The flag stays set until software writes a one to that bit through a dedicated clear path. Reading the flags does not clear them.

Each flag is ANDed with a per-key enable mask. All the masked flags are ORed into a single interrupt line. When the unit is disabled, edge detection stops and the stored previous status keeps following the live status. On re-enable, a key that changed while the unit was off raises no flag.

Key k sits at row k/8, column k%8. It uses status bit k, flag bit k and mask bit k. Its edge selector is bits 2k+1 down to 2k of the edge-mode bus, so each 32-bit quarter of that bus covers 16 keys. The flag vector is split into two 32-bit clear words: word 0 holds keys 0 to 31 (rows 0 to 3) and word 1 holds keys 32 to 63 (rows 4 to 7).

Top module: `key_edge_irq_unit`

## Requirements
- R1: After reset all raw flags, all masked flags and the irq output are 0.
- R2: With edge selector value 1, a 0-to-1 change of a key's status sets its raw flag at the first clock edge that samples the new status. A 1-to-0 change sets nothing.
- R3: With edge selector value 2, only a 1-to-0 change of a key's status sets its raw flag, with the same one-edge timing.
- R4: With edge selector value 3, both directions of change set the raw flag.
- R5: With edge selector value 0, no change of a key's status sets its flag.
- R6: Key k uses status bit k, raw and masked flag bit k, mask bit k, and edge selector bits [2k+1:2k]. An edge on one key sets no flag of any other key.
- R7: A raw flag stays set after the key status returns to its earlier value, until it is cleared.
- R8: With clear strobe bit w high, every raw flag in word w (keys 32w to 32w+31) whose bit in the clear data is 1 is cleared at the next clock edge. Flags whose clear data bit is 0, and all flags of the other word, are kept.
- R9: If a qualifying edge and a clear of the same key arrive in the same cycle, the flag ends up set.
- R10: The masked flags equal the raw flags ANDed with the mask, and irq is 1 exactly when any masked flag is 1. The mask has no effect on the raw flags.
- R11: While enable is 0, status changes set no flag. In the first cycle enable is 1, no flag is set either, even if the status differs from its value before enable. From the following cycle on, edges are detected normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable; edge detection runs while high |
| key_status | input | 64 | Debounced key status, bit k for key k |
| edge_mode | input | 128 | Two-bit edge selector per key (0 off, 1 rise, 2 fall, 3 both) |
| irq_mask | input | 64 | Per-key interrupt enable, 1 enables |
| clr_strobe | input | 2 | Clear strobe per 32-bit flag word |
| clr_data | input | 32 | Write-one-to-clear data applied to the strobed word(s) |
| raw_flags | output | 64 | Sticky per-key edge flags |
| masked_flags | output | 64 | Raw flags ANDed with the mask |
| irq | output | 1 | OR of all masked flags |

## Verification
Each edge selector value is driven with a rising change and with a falling change on the same key. This shows that the selector decodes direction, not just change. The field-position test gives only one key in the upper word a non-zero selector while its neighbours toggle as well, so any wrong bit slicing of the selector or the flags shows up. Partial clears are run per word, and a clear is made to coincide with a new edge; together these separate write-one-to-clear from clear-all and show that the set takes priority. Mask changes over fixed flags, status changes while disabled, and a status change on the enabling cycle itself separate the masking and the enable reload from the edge logic.

// File: rtl/kei_pkg.sv
package kei_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  // Decide whether a sampled transition qualifies under a selector.
  function automatic logic edge_qualifies(input logic [1:0] sel,
                                          input logic prev_v,
                                          input logic cur_v);
    logic rise_v;
    logic fall_v;
    logic res;
    rise_v = ~prev_v & cur_v;
    fall_v = prev_v & ~cur_v;
    case (edge_sel_e'(sel))
      EDGE_RISE: res = rise_v;
      EDGE_FALL: res = fall_v;
      EDGE_BOTH: res = rise_v | fall_v;
      default:   res = 1'b0;
    endcase
    return res;
  endfunction

  // Write-one-to-clear update with set priority.
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] set_v,
                                            input logic        clr_en,
                                            input logic [31:0] clr_v);
    logic [31:0] kept;
    kept = clr_en ? (cur & ~clr_v) : cur;
    return kept | set_v;
  endfunction

endpackage

// File: rtl/key_edge_detect.sv
module key_edge_detect #(
  parameter int NUM_KEYS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [NUM_KEYS-1:0]   key_status,
  input  logic [2*NUM_KEYS-1:0] edge_mode,
  output logic [NUM_KEYS-1:0]   edge_hit,
  output logic                  armed
);
  import kei_pkg::*;

  logic [NUM_KEYS-1:0] prev_status;
  logic                en_q;

  // Previous status follows the live status every cycle, so it is
  // already current when detection is switched back on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_status <= '0;
      en_q        <= 1'b0;
    end else begin
      prev_status <= key_status;
      en_q        <= enable;
    end
  end

  assign armed = enable & en_q;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign edge_hit[k] = armed &
      edge_qualifies(edge_mode[2*k +: 2], prev_status[k], key_status[k]);
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (edge_hit == '0));  // R11
  AST_NO_EDGE_AT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |-> (edge_hit == '0));  // R11

endmodule

// File: rtl/key_flag_bank.sv
module key_flag_bank #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_bits,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_bits,
  output logic [WORD_W-1:0] flags
);
  import kei_pkg::*;

  logic [31:0] set_ext;
  logic [31:0] clr_ext;
  logic [31:0] cur_ext;
  logic [31:0] nxt_ext;

  always_comb begin
    set_ext = '0;
    clr_ext = '0;
    cur_ext = '0;
    set_ext[WORD_W-1:0] = set_bits;
    clr_ext[WORD_W-1:0] = clr_bits;
    cur_ext[WORD_W-1:0] = flags;
    nxt_ext = flag_next(cur_ext, set_ext, clr_en, clr_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt_ext[WORD_W-1:0];
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((flags & $past(set_bits)) == $past(set_bits)));  // R9
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((flags & $past(clr_bits & ~set_bits)) == '0));  // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (($past(flags) & ~flags) == '0));  // R7

endmodule

// File: rtl/key_edge_irq_unit.sv
module key_edge_irq_unit #(
  parameter int NUM_KEYS = 64,
  parameter int WORD_W   = 32,
  localparam int NUM_WORDS = NUM_KEYS / WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [NUM_KEYS-1:0]   key_status,
  input  logic [2*NUM_KEYS-1:0] edge_mode,
  input  logic [NUM_KEYS-1:0]   irq_mask,
  input  logic [NUM_WORDS-1:0]  clr_strobe,
  input  logic [WORD_W-1:0]     clr_data,
  output logic [NUM_KEYS-1:0]   raw_flags,
  output logic [NUM_KEYS-1:0]   masked_flags,
  output logic                  irq
);

  logic [NUM_KEYS-1:0] edge_hit;
  logic                det_armed;

  key_edge_detect #(.NUM_KEYS(NUM_KEYS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .key_status(key_status),
    .edge_mode (edge_mode),
    .edge_hit  (edge_hit),
    .armed     (det_armed)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    key_flag_bank #(.WORD_W(WORD_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_bits(edge_hit[w*WORD_W +: WORD_W]),
      .clr_en  (clr_strobe[w]),
      .clr_bits(clr_data),
      .flags   (raw_flags[w*WORD_W +: WORD_W])
    );
  end

  assign masked_flags = raw_flags & irq_mask;
  assign irq          = |masked_flags;

  AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_flags & irq_mask) == '0) |-> !irq);  // R10
  AST_FLAG_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_armed && clr_strobe == '0) |=> $stable(raw_flags));  // R11

endmodule

// File: tb/key_edge_irq_unit_tb_top.sv
module key_edge_irq_unit_tb_top;
  localparam int NK = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [NK-1:0] key_status = '0;
  logic [2*NK-1:0] edge_mode = '0;
  logic [NK-1:0] irq_mask = '0;
  logic [1:0]    clr_strobe = '0;
  logic [31:0]   clr_data = '0;
  logic [NK-1:0] raw_flags;
  logic [NK-1:0] masked_flags;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  key_edge_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .key_status(key_status),
    .edge_mode(edge_mode), .irq_mask(irq_mask), .clr_strobe(clr_strobe),
    .clr_data(clr_data), .raw_flags(raw_flags), .masked_flags(masked_flags),
    .irq(irq)
  );

  function automatic logic [2*NK-1:0] all_modes(input logic [1:0] m);
    logic [2*NK-1:0] r;
    for (int k = 0; k < NK; k++) r[2*k +: 2] = m;
    return r;
  endfunction

  function automatic logic [NK-1:0] bit_of(input int k);
    logic [NK-1:0] r;
    r = '0;
    r[k] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NK-1:0] got, input logic [NK-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_strobe = 2'b11;
    clr_data = '1;
    tick();
    clr_strobe = 2'b00;
    clr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 raw", raw_flags, '0);
    chk("R1 masked", masked_flags, '0);
    chk("R1 irq", {63'd0, irq}, '0);
  endtask

  task automatic t_rise();
    edge_mode = all_modes(2'd1);
    clear_all();
    key_status = bit_of(5);
    tick();
    chk("R2 rise", raw_flags, bit_of(5));
    clear_all();
    key_status = '0;
    tick();
    chk("R2 fall ignored", raw_flags, '0);
  endtask

  task automatic t_fall();
    edge_mode = all_modes(2'd2);
    clear_all();
    key_status = bit_of(12);
    tick();
    chk("R3 rise ignored", raw_flags, '0);
    key_status = '0;
    tick();
    chk("R3 fall", raw_flags, bit_of(12));
  endtask

  task automatic t_both();
    edge_mode = all_modes(2'd3);
    clear_all();
    key_status = bit_of(0) | bit_of(63);
    tick();
    chk("R4 rise", raw_flags, bit_of(0) | bit_of(63));
    clear_all();
    key_status = bit_of(0);
    tick();
    chk("R4 fall", raw_flags, bit_of(63));
  endtask

  task automatic t_off();
    edge_mode = all_modes(2'd0);
    clear_all();
    key_status = '1;
    tick();
    chk("R5 rise", raw_flags, '0);
    key_status = '0;
    tick();
    chk("R5 fall", raw_flags, '0);
  endtask

  task automatic t_map();
    edge_mode = '0;
    edge_mode[75:74] = 2'd3;
    clear_all();
    key_status = bit_of(36) | bit_of(37) | bit_of(38);
    tick();
    chk("R6 key37 only", raw_flags, bit_of(37));
  endtask

  task automatic t_sticky();
    edge_mode = all_modes(2'd1);
    key_status = '0;
    tick();
    clear_all();
    key_status = bit_of(20);
    tick();
    repeat (5) tick();
    key_status = '0;
    tick();
    tick();
    chk("R7 sticky", raw_flags, bit_of(20));
  endtask

  task automatic t_clear();
    edge_mode = all_modes(2'd3);
    clear_all();
    key_status = bit_of(3) | bit_of(40) | bit_of(41);
    tick();
    chk("R8 setup", raw_flags, bit_of(3) | bit_of(40) | bit_of(41));
    clr_strobe = 2'b10;
    clr_data = 32'h0000_0200;
    tick();
    clr_strobe = 2'b00;
    chk("R8 word1 bit9", raw_flags, bit_of(3) | bit_of(40));
    clr_strobe = 2'b01;
    clr_data = 32'h0000_0108;
    tick();
    clr_strobe = 2'b00;
    clr_data = '0;
    chk("R8 word0 bit3", raw_flags, bit_of(40));
    clear_all();
  endtask

  task automatic t_setwins();
    edge_mode = all_modes(2'd3);
    clear_all();
    key_status = key_status ^ bit_of(6);
    tick();
    key_status = key_status ^ bit_of(7);
    clr_strobe = 2'b01;
    clr_data = '1;
    tick();
    clr_strobe = 2'b00;
    clr_data = '0;
    chk("R9 set wins", raw_flags, bit_of(7));
    clear_all();
  endtask

  task automatic t_mask();
    edge_mode = all_modes(2'd3);
    clear_all();
    key_status = key_status ^ (bit_of(3) | bit_of(40));
    irq_mask = '0;
    tick();
    chk("R10 raw unmasked", raw_flags, bit_of(3) | bit_of(40));
    chk("R10 masked zero", masked_flags, '0);
    chk("R10 irq low", {63'd0, irq}, '0);
    irq_mask = bit_of(40);
    tick();
    chk("R10 masked", masked_flags, bit_of(40));
    chk("R10 irq high", {63'd0, irq}, 64'd1);
    clr_strobe = 2'b10;
    clr_data = '1;
    tick();
    clr_strobe = 2'b00;
    clr_data = '0;
    chk("R10 irq after clear", {63'd0, irq}, '0);
    chk("R10 raw kept", raw_flags, bit_of(3));
    irq_mask = '0;
    clear_all();
  endtask

  task automatic t_enable();
    edge_mode = all_modes(2'd3);
    clear_all();
    enable = 1'b0;
    key_status = key_status ^ 64'h00FF_0000_F0F0_0F0F;
    tick();
    chk("R11 disabled", raw_flags, '0);
    tick();
    key_status = key_status ^ 64'h1234_5678_9ABC_DEF0;
    enable = 1'b1;
    tick();
    chk("R11 enable cycle", raw_flags, '0);
    tick();
    chk("R11 after enable", raw_flags, '0);
    key_status = key_status ^ bit_of(1);
    tick();
    chk("R11 detecting again", raw_flags, bit_of(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    tick();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_map();
    t_sticky();
    t_clear();
    t_setwins();
    t_mask();
    t_enable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule